// File: doc/BRIEF.md
# Stepped Control Sequencer

This block drives the datapath of a one-instruction (subtract and branch if less or equal) processor. Each instruction runs in a fixed number of steps. A three-bit step counter is decoded into one-hot step lines, and each strobe of the datapath is formed from those lines. The inputs are two status flags: the less-or-equal result of the subtractor and the detector that marks an operand address as the I/O location.

There are seven steps, 0 to 6:

- Step 0 loads the first operand address into the transfer register.
- Step 1 reads that operand into the A register.
- Step 2 advances the PC and loads the second operand address.
- Step 3 reads that operand into the B register.
- Step 4 advances the PC.
- Step 5 places the subtract result on the bus and writes it back.
- Step 6 ends the instruction. It either advances the PC or loads the PC with the branch target, depending on the flag.

Step 7 is never entered. The counter returns to step 0 after step 6.

Register strobes are ANDed with the low phase of the clock. The counter advances on the rising edge, so each capturing edge falls in the middle of a step, after memory data has settled. Bus-control levels stay valid for the whole step. When the I/O detector is set, the input port replaces the RAM read and the output register replaces the RAM write.

Top module: `step_sequencer`

## Requirements
- R1: While `rst_n` is low, the step is 0 (`step_oh` = 8'b0000_0001) and every strobe output is low.
- R2: `step_oh` is one-hot, with bit n meaning step n. The step advances by one on each rising edge from 0 through 6, then returns to 0. Bit 7 is never set.
- R3: The edge strobes (`inc_pc`, `ld_pc`, `ld_xfr`, `ld_a`, `ld_b`, `ld_out`, `wr_ram`) are asserted only while `clk` is low. The level strobes (`ram_deny`, `en_inp`, `en_res`, `sel_xfr`) hold for the whole step.
- R4: `inc_pc` pulses in steps 2 and 4. It also pulses in step 6 when `leq` is 0.
- R5: `ld_pc` pulses only in step 6 and only when `leq` is 1. It is never active together with `inc_pc`.
- R6: `ld_xfr` pulses in steps 0 and 2, while `sel_xfr` is 0 so the PC addresses memory. `sel_xfr` is 1 in steps 1, 3 and 5 and 0 in all other steps.
- R7: `ld_a` pulses in step 1 only and `ld_b` pulses in step 3 only.
- R8: In step 5, `en_res` and `ram_deny` are 1. If `iod` is 0, `wr_ram` pulses and `ld_out` stays 0. If `iod` is 1, `ld_out` pulses and `wr_ram` stays 0. `en_res`, `wr_ram` and `ld_out` are 0 in every other step.
- R9: In steps 1 and 3 with `iod` = 1, `en_inp` and `ram_deny` are 1. With `iod` = 0, both are 0. `en_inp` is 0 in all other steps.
- R10: `wr_ram` is never 1 unless `ram_deny` is 1, and `en_inp` and `en_res` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock; rising edge advances the step |
| rst_n | input | 1 | Asynchronous active-low reset |
| leq | input | 1 | Subtract result was less than or equal to zero |
| iod | input | 1 | Current operand address is the I/O location |
| step_oh | output | 8 | One-hot current step |
| inc_pc | output | 1 | Increment PC (edge strobe) |
| ld_pc | output | 1 | Load PC from data bus (edge strobe) |
| ld_xfr | output | 1 | Load transfer register (edge strobe) |
| ld_a | output | 1 | Load A register (edge strobe) |
| ld_b | output | 1 | Load B register (edge strobe) |
| ld_out | output | 1 | Load output register (edge strobe) |
| wr_ram | output | 1 | RAM write (edge strobe) |
| ram_deny | output | 1 | Keep RAM off the data bus (level) |
| en_inp | output | 1 | Drive input port onto data bus (level) |
| en_res | output | 1 | Drive subtract result onto data bus (level) |
| sel_xfr | output | 1 | Address source: 1 transfer register, 0 PC (level) |

## Verification
The assertions assume that `leq` and `iod` change only while `clk` is high, and never in the low half where the edge strobes are formed. They also assume that reset is released away from a rising edge. The stimulus updates both flags half a nanosecond after each rising edge, with values from a seeded `$urandom` stream. Directed stretches hold each flag combination for full instructions, so steps 1, 3, 5 and 6 are seen under both values of each flag.

// File: rtl/step_sequencer.sv
`timescale 1ns/100ps
module step_sequencer #(
  parameter int STEP_W = 3,
  parameter int LAST   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 leq,
  input  logic                 iod,
  output logic [2**STEP_W-1:0] step_oh,
  output logic                 inc_pc,
  output logic                 ld_pc,
  output logic                 ld_xfr,
  output logic                 ld_a,
  output logic                 ld_b,
  output logic                 ld_out,
  output logic                 wr_ram,
  output logic                 ram_deny,
  output logic                 en_inp,
  output logic                 en_res,
  output logic                 sel_xfr
);
  localparam int NSTEP = 2**STEP_W;
  localparam logic [STEP_W-1:0] LAST_C = STEP_W'(LAST);

  logic [STEP_W-1:0] cnt;
  logic              ph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             cnt <= '0;
    else if (cnt == LAST_C) cnt <= '0;
    else                    cnt <= cnt + 1'b1;

  assign step_oh = NSTEP'(1) << cnt;

  // second half of a step, after memory data settles
  assign ph = rst_n & ~clk;

  wire opr = step_oh[1] | step_oh[3];

  assign sel_xfr  = rst_n & (opr | step_oh[5]);
  assign en_inp   = rst_n & opr & iod;
  assign en_res   = rst_n & step_oh[5];
  assign ram_deny = en_res | en_inp;

  assign ld_xfr = ph & (step_oh[0] | step_oh[2]);
  assign ld_a   = ph & step_oh[1];
  assign ld_b   = ph & step_oh[3];
  assign wr_ram = ph & step_oh[5] & ~iod;
  assign ld_out = ph & step_oh[5] & iod;
  assign inc_pc = ph & (step_oh[2] | step_oh[4] | (step_oh[6] & ~leq));
  assign ld_pc  = ph & step_oh[6] & leq;
endmodule

// File: rtl/step_sequencer_chk.sv
`timescale 1ns/100ps
module step_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       leq,
  input logic       iod,
  input logic [7:0] step_oh,
  input logic       inc_pc,
  input logic       ld_pc,
  input logic       ld_xfr,
  input logic       ld_a,
  input logic       ld_b,
  input logic       ld_out,
  input logic       wr_ram,
  input logic       ram_deny,
  input logic       en_inp,
  input logic       en_res,
  input logic       sel_xfr
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_oh) == 1);
  p_no_step7_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_oh[7]);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[6] |=> step_oh[0]);
  p_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[5] |-> (en_res && ram_deny));
  p_addr_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_oh[0] || step_oh[2] || step_oh[4] || step_oh[6]) |-> !sel_xfr);

  always_comb begin
    if (rst_n) begin
      p_pc_excl_r5: assert (!(inc_pc && ld_pc));
      p_wr_deny_r10: assert (!wr_ram || ram_deny);
      p_bus_excl_r10: assert (!(en_inp && en_res));
      p_gate_r3: assert (!clk || !(inc_pc | ld_pc | ld_xfr | ld_a | ld_b | ld_out | wr_ram));
    end
  end
endmodule

bind step_sequencer step_sequencer_chk u_chk (.*);

// File: tb/test_step_sequencer.sv
`timescale 1ns/100ps
module test_step_sequencer;
  logic clk = 1'b0, rst_n = 1'b0, leq = 1'b0, iod = 1'b0;
  logic [7:0] step_oh;
  logic inc_pc, ld_pc, ld_xfr, ld_a, ld_b, ld_out, wr_ram, ram_deny, en_inp, en_res, sel_xfr;
  int checks = 0, fails = 0;
  bit done = 0;

  step_sequencer i_step_sequencer (.*);

  always #2.5 clk = ~clk;

  // bit order: inc_pc ld_pc ld_xfr ld_a ld_b ld_out wr_ram ram_deny en_inp en_res sel_xfr
  function automatic logic [10:0] exp_strb(int s, bit l, bit io, bit lo);
    logic [10:0] v = '0;
    bit opr = (s == 1) || (s == 3);
    v[0] = opr || s == 5;
    v[1] = (s == 5);
    v[2] = opr && io;
    v[3] = (s == 5) || (opr && io);
    if (lo) begin
      v[4]  = (s == 5) && !io;
      v[5]  = (s == 5) && io;
      v[6]  = (s == 3);
      v[7]  = (s == 1);
      v[8]  = (s == 0) || (s == 2);
      v[9]  = (s == 6) && l;
      v[10] = (s == 2) || (s == 4) || (s == 6 && !l);
    end
    return v;
  endfunction

  function automatic string tag(int b, bit lo);
    if (!lo && b >= 4) return "R3";
    case (b)
      10: return "R4";
      9: return "R5";
      8, 0: return "R6";
      7, 6: return "R7";
      2: return "R9";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [10:0] act_strb();
    return {inc_pc, ld_pc, ld_xfr, ld_a, ld_b, ld_out, wr_ram, ram_deny, en_inp, en_res, sel_xfr};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_step(int s, bit lo);
    logic [10:0] a = act_strb();
    logic [10:0] e = exp_strb(s, leq, iod, lo);
    chk("R2", step_oh, 32'(8'b1 << s));
    for (int b = 0; b < 11; b++) chk(tag(b, lo), a[b], e[b]);
    chk("R10", (wr_ram && !ram_deny) || (en_inp && en_res), 0);
    chk("R5", inc_pc && ld_pc, 0);
  endtask

  task automatic run_step(int s, bit l, bit io);
    leq = l; iod = io;
    #1;   chk_step(s, 0);
    #2.5; chk_step(s, 1);
  endtask

  initial begin
    int s;
    void'($urandom(32'd2024));
    // R1: reset state in both clock phases
    repeat (3) begin
      @(posedge clk); leq = $urandom; iod = $urandom;
      #1;   chk("R1", step_oh, 8'h01); chk("R1", act_strb(), 0);
      #2.5; chk("R1", step_oh, 8'h01); chk("R1", act_strb(), 0);
    end
    @(posedge clk); #0.5; rst_n = 1'b1;
    s = 0;
    run_step(s, 0, 0);
    // directed: each flag combination for two full instructions
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 14; k++) begin
        @(posedge clk); #0.5;
        s = (s == 6) ? 0 : s + 1;
        run_step(s, c[0], c[1]);
      end
    // random flags
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #0.5;
      s = (s == 6) ? 0 : s + 1;
      run_step(s, 1'($urandom), 1'($urandom));
    end
    // R1: reset mid-instruction returns to step 0
    #1; rst_n = 1'b0; #0.5;
    chk("R1", step_oh, 8'h01); chk("R1", act_strb(), 0);
    @(posedge clk); #0.5; rst_n = 1'b1;
    run_step(0, 1, 1);
    @(posedge clk); #0.5; run_step(1, 1, 1);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule